// File: doc/BRIEF.md
# Precise In-Order Interrupt Sequencer

This block sits at the completion stage of a simple in-order pipeline and decides when an interrupt is taken. Execution units may flag exception causes on any in-flight instruction in any order. Each report carries the instruction's program-order tag, and the sequencer keeps the causes per tag. A cause is acted on only when its instruction is the oldest one and reaches completion, so interrupts reach software strictly in program order. When an instruction has several causes, they are delivered one per handler entry.

Asynchronous requests are precise. They wait until the completion stage is idle or its instruction completes cleanly, and until the completed-store queue has drained. A system-reset request and a machine-check request override everything, even while a handler is running. When an interrupt is taken, the block pulses a strobe for one cycle and presents the interrupt type, a vector address and a return address. It then holds a supervisor-mode flag until a return-from-interrupt is signalled.

Top module: `prec_irq_seq`

## Requirements
- R1: After reset, irq_take and sup_mode are 0.
- R2: Causes are stored by tag. The oldest instruction's interrupt is taken first, whatever order the reports arrived in. A report aimed at the head tag in its completing cycle takes part in that cycle's decision.
- R3: An instruction cause is taken only in a cycle with cmp_valid and cmp_done. In that case irq_type is 2 plus the cause bit index and irq_ret is cmp_pc, and the instruction is not retired.
- R4: An instruction with several cause bits raises them one at a time, lowest bit index first. Each later one needs a return-from-interrupt and a fresh completion. Once no causes remain, the completion retires the instruction with no interrupt.
- R5: An asynchronous request is taken only when sq_empty is 1 and either cmp_valid is 0 or the head completes with no cause. irq_type is 2+NUM_EXC plus the lowest set request index. irq_ret is cmp_next_pc when an instruction completed that cycle and cmp_pc otherwise.
- R6: While sup_mode is 1, no instruction cause or asynchronous request is taken and cmp_done retires nothing. rfi clears sup_mode.
- R7: rst_req takes type 0 and mck_req takes type 1, even while sup_mode is 1, with irq_ret equal to cmp_pc. rst_req also discards every stored cause and resets the head tag to 0.
- R8: When requests coincide, the priority is rst_req, then mck_req, then the head instruction's cause, then asynchronous requests.
- R9: An interrupt decided in cycle t shows as a one-cycle irq_take in cycle t+1, with sup_mode set and irq_vec equal to VEC_BASE + irq_type*0x100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | A cause report is present |
| exc_tag | input | TAG_W | Program-order tag of the reported instruction |
| exc_cause | input | NUM_EXC | Cause bits of the report |
| cmp_valid | input | 1 | Completion stage holds the head instruction |
| cmp_done | input | 1 | Head instruction finishes this cycle |
| cmp_pc | input | AW | Head instruction address, or next address when the stage is empty |
| cmp_next_pc | input | AW | Address following the head instruction |
| sq_empty | input | 1 | Completed-store queue is drained |
| async_req | input | NUM_ASYNC | Asynchronous interrupt requests |
| rst_req | input | 1 | System-reset interrupt request |
| mck_req | input | 1 | Machine-check request |
| rfi | input | 1 | Return from interrupt |
| irq_take | output | 1 | Interrupt taken strobe |
| irq_type | output | TYPE_W | Taken interrupt type |
| irq_vec | output | AW | Vector address |
| irq_ret | output | AW | Saved return address |
| sup_mode | output | 1 | Supervisor mode, handler active |

## Verification
The bench builds the block with TAG_W=2, NUM_EXC=3 and NUM_ASYNC=2. With four tag slots, the head wraps several times during a run. Three cause bits allow every one of the seven cause masks to be walked through sequential delivery. Two asynchronous lines allow every request mask to be crossed with store-queue state and the three completion-stage conditions. All sixteen combinations of reset, machine check, head cause and asynchronous request are also swept, so each priority pairing is observed at the ports.

// File: rtl/prec_irq_pkg.sv
package prec_irq_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_RST  = 3'd1,
    SRC_MCK  = 3'd2,
    SRC_EXC  = 3'd3,
    SRC_ASY  = 3'd4
  } irq_src_e;

  localparam int unsigned VEC_STEP_SH = 8;
  localparam int unsigned TYPE_RST    = 0;
  localparam int unsigned TYPE_MCK    = 1;
  localparam int unsigned TYPE_EXC0   = 2;
endpackage

// File: rtl/ios_lowest.sv
module ios_lowest #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/ios_slot_file.sv
module ios_slot_file #(
  parameter int unsigned TAG_W   = 2,
  parameter int unsigned NUM_EXC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               set_en,
  input  logic [TAG_W-1:0]   set_tag,
  input  logic [NUM_EXC-1:0] set_bits,
  input  logic               clr_en,
  input  logic [TAG_W-1:0]   clr_tag,
  input  logic [NUM_EXC-1:0] clr_bits,
  input  logic [TAG_W-1:0]   rd_tag,
  output logic [NUM_EXC-1:0] rd_bits
);
  localparam int unsigned DEPTH = 1 << TAG_W;

  logic [DEPTH*NUM_EXC-1:0] all_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [NUM_EXC-1:0] q;
    logic [NUM_EXC-1:0] d;
    logic               hit_set;
    logic               hit_clr;
    logic               en;

    assign hit_set = set_en && (set_tag == TAG_W'(g));
    assign hit_clr = clr_en && (clr_tag == TAG_W'(g));
    assign en      = flush || hit_set || hit_clr;

    always_comb begin
      d = q;
      if (hit_set) d = d | set_bits;
      if (hit_clr) d = d & ~clr_bits;
      if (flush)   d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign all_q[g*NUM_EXC +: NUM_EXC] = q;
  end

  assign rd_bits = all_q[rd_tag*NUM_EXC +: NUM_EXC];
endmodule

// File: rtl/prec_irq_seq.sv
module prec_irq_seq
  import prec_irq_pkg::*;
#(
  parameter int unsigned TAG_W     = 2,
  parameter int unsigned NUM_EXC   = 3,
  parameter int unsigned NUM_ASYNC = 2,
  parameter int unsigned AW        = 32,
  parameter logic [AW-1:0] VEC_BASE = 32'hFFF0_0000,
  localparam int unsigned NTYPE    = 2 + NUM_EXC + NUM_ASYNC,
  localparam int unsigned TYPE_W   = $clog2(NTYPE)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 exc_valid,
  input  logic [TAG_W-1:0]     exc_tag,
  input  logic [NUM_EXC-1:0]   exc_cause,
  input  logic                 cmp_valid,
  input  logic                 cmp_done,
  input  logic [AW-1:0]        cmp_pc,
  input  logic [AW-1:0]        cmp_next_pc,
  input  logic                 sq_empty,
  input  logic [NUM_ASYNC-1:0] async_req,
  input  logic                 rst_req,
  input  logic                 mck_req,
  input  logic                 rfi,
  output logic                 irq_take,
  output logic [TYPE_W-1:0]    irq_type,
  output logic [AW-1:0]        irq_vec,
  output logic [AW-1:0]        irq_ret,
  output logic                 sup_mode
);
  localparam int unsigned EXC_IW   = (NUM_EXC > 1) ? $clog2(NUM_EXC) : 1;
  localparam int unsigned ASY_IW   = (NUM_ASYNC > 1) ? $clog2(NUM_ASYNC) : 1;
  localparam int unsigned ASY_BASE = TYPE_EXC0 + NUM_EXC;

  logic [TAG_W-1:0]   head_q, head_d;
  logic               busy_q, busy_d;
  logic               take_q, take_d;
  logic [TYPE_W-1:0]  type_q, type_d;
  logic [AW-1:0]      vec_q, vec_d;
  logic [AW-1:0]      ret_q, ret_d;

  logic [NUM_EXC-1:0] stored_bits;
  logic [NUM_EXC-1:0] head_bits;
  logic               exc_any, asy_any;
  logic [EXC_IW-1:0]  exc_idx;
  logic [ASY_IW-1:0]  asy_idx;
  logic               head_fin, stage_free;
  logic               exc_go, asy_go, retire;
  irq_src_e           src;

  ios_slot_file #(.TAG_W(TAG_W), .NUM_EXC(NUM_EXC)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (src == SRC_RST),
    .set_en   (exc_valid),
    .set_tag  (exc_tag),
    .set_bits (exc_cause),
    .clr_en   (src == SRC_EXC),
    .clr_tag  (head_q),
    .clr_bits (NUM_EXC'(1) << exc_idx),
    .rd_tag   (head_q),
    .rd_bits  (stored_bits)
  );

  // a report for the head in its completing cycle joins the decision
  assign head_bits = stored_bits |
                     ((exc_valid && exc_tag == head_q) ? exc_cause : '0);

  ios_lowest #(.N(NUM_EXC), .IW(EXC_IW)) u_exc_pick (
    .req (head_bits), .any (exc_any), .idx (exc_idx)
  );

  ios_lowest #(.N(NUM_ASYNC), .IW(ASY_IW)) u_asy_pick (
    .req (async_req), .any (asy_any), .idx (asy_idx)
  );

  assign head_fin   = cmp_valid && cmp_done;
  assign stage_free = !cmp_valid || (head_fin && !exc_any);
  assign exc_go     = !busy_q && head_fin && exc_any;
  assign asy_go     = !busy_q && asy_any && sq_empty && stage_free;
  assign retire     = !busy_q && head_fin && !exc_any && !rst_req && !mck_req;

  always_comb begin
    if (rst_req)      src = SRC_RST;
    else if (mck_req) src = SRC_MCK;
    else if (exc_go)  src = SRC_EXC;
    else if (asy_go)  src = SRC_ASY;
    else              src = SRC_NONE;
  end

  always_comb begin
    take_d = (src != SRC_NONE);
    ret_d  = cmp_pc;
    case (src)
      SRC_RST: type_d = TYPE_W'(TYPE_RST);
      SRC_MCK: type_d = TYPE_W'(TYPE_MCK);
      SRC_EXC: type_d = TYPE_W'(TYPE_EXC0) + TYPE_W'(exc_idx);
      SRC_ASY: begin
        type_d = TYPE_W'(ASY_BASE) + TYPE_W'(asy_idx);
        if (cmp_valid) ret_d = cmp_next_pc;
      end
      default: type_d = '0;
    endcase
    vec_d = VEC_BASE + (AW'(type_d) << VEC_STEP_SH);
  end

  always_comb begin
    head_d = head_q;
    if (src == SRC_RST) head_d = '0;
    else if (retire)    head_d = head_q + TAG_W'(1);
  end

  always_comb begin
    busy_d = busy_q;
    if (take_d)   busy_d = 1'b1;
    else if (rfi) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      busy_q <= 1'b0;
      take_q <= 1'b0;
    end else begin
      head_q <= head_d;
      busy_q <= busy_d;
      take_q <= take_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      vec_q  <= '0;
      ret_q  <= '0;
    end else if (take_d) begin
      type_q <= type_d;
      vec_q  <= vec_d;
      ret_q  <= ret_d;
    end
  end

  assign irq_take = take_q;
  assign irq_type = type_q;
  assign irq_vec  = vec_q;
  assign irq_ret  = ret_q;
  assign sup_mode = busy_q;
endmodule

// File: rtl/prec_irq_seq_chk.sv
module prec_irq_seq_chk #(
  parameter int unsigned NUM_EXC = 3,
  parameter int unsigned AW      = 32,
  parameter int unsigned TYPE_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_req,
  input logic              mck_req,
  input logic              rfi,
  input logic              sq_empty,
  input logic              irq_take,
  input logic [TYPE_W-1:0] irq_type,
  input logic [AW-1:0]     irq_vec,
  input logic              sup_mode
);
  localparam int unsigned ASY_BASE = 2 + NUM_EXC;

  // R9
  take_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> sup_mode);

  // R9
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> ((irq_vec & AW'(255)) == '0));

  // R6
  single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_mode && !rfi && !rst_req && !mck_req) |=> !irq_take);

  // R5
  async_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_type >= TYPE_W'(ASY_BASE)) |-> $past(sq_empty));

  // R7
  rst_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (irq_take && irq_type == '0));

  // R8
  mck_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mck_req && !rst_req) |=> (irq_take && irq_type == TYPE_W'(1)));
endmodule

bind prec_irq_seq prec_irq_seq_chk #(
  .NUM_EXC (NUM_EXC),
  .AW      (AW),
  .TYPE_W  (TYPE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_req  (rst_req),
  .mck_req  (mck_req),
  .rfi      (rfi),
  .sq_empty (sq_empty),
  .irq_take (irq_take),
  .irq_type (irq_type),
  .irq_vec  (irq_vec),
  .sup_mode (sup_mode)
);

// File: tb/prec_irq_seq_bench.sv
module prec_irq_seq_bench;
  localparam int unsigned TAG_W = 2;
  localparam int unsigned NEXC  = 3;
  localparam int unsigned NASY  = 2;
  localparam int unsigned AW    = 32;
  localparam logic [31:0] BASE  = 32'hFFF0_0000;

  logic            clk, rst_n;
  logic            exc_valid;
  logic [TAG_W-1:0] exc_tag;
  logic [NEXC-1:0] exc_cause;
  logic            cmp_valid, cmp_done;
  logic [AW-1:0]   cmp_pc, cmp_next_pc;
  logic            sq_empty;
  logic [NASY-1:0] async_req;
  logic            rst_req, mck_req, rfi;
  logic            irq_take;
  logic [2:0]      irq_type;
  logic [AW-1:0]   irq_vec, irq_ret;
  logic            sup_mode;

  int checks = 0;
  int errors = 0;
  logic [TAG_W-1:0] hd;

  prec_irq_seq #(.TAG_W(TAG_W), .NUM_EXC(NEXC), .NUM_ASYNC(NASY), .AW(AW),
                 .VEC_BASE(BASE)) u_prec_irq_seq (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_tag(exc_tag),
    .exc_cause(exc_cause), .cmp_valid(cmp_valid), .cmp_done(cmp_done),
    .cmp_pc(cmp_pc), .cmp_next_pc(cmp_next_pc), .sq_empty(sq_empty),
    .async_req(async_req), .rst_req(rst_req), .mck_req(mck_req), .rfi(rfi),
    .irq_take(irq_take), .irq_type(irq_type), .irq_vec(irq_vec),
    .irq_ret(irq_ret), .sup_mode(sup_mode)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr_in();
    exc_valid = 0; exc_tag = '0; exc_cause = '0;
    cmp_valid = 0; cmp_done = 0; cmp_pc = '0; cmp_next_pc = '0;
    sq_empty = 1; async_req = '0; rst_req = 0; mck_req = 0; rfi = 0;
  endtask

  task automatic chk_take(string req, logic et, int ety, logic [31:0] eret);
    logic bad;
    checks++;
    bad = (irq_take !== et);
    if (et) bad = bad || (int'(irq_type) != ety) || (irq_ret !== eret) ||
                  (irq_vec !== BASE + 32'(ety) * 32'h100) || (sup_mode !== 1'b1);
    if (bad) begin
      errors++;
      $display("FAIL %s: take=%0b type=%0d ret=%h vec=%h sup=%0b expected take=%0b type=%0d ret=%h vec=%h",
               req, irq_take, irq_type, irq_ret, irq_vec, sup_mode, et, ety, eret,
               BASE + 32'(ety) * 32'h100);
    end
  endtask

  task automatic chk_sup(string req, logic e);
    checks++;
    if (sup_mode !== e) begin
      errors++;
      $display("FAIL %s: sup_mode=%0b expected %0b", req, sup_mode, e);
    end
  endtask

  task automatic rfi_pulse();
    rfi = 1; tick(); rfi = 0;
    chk_sup("R6 rfi clears", 1'b0);
  endtask

  task automatic report(logic [TAG_W-1:0] t, logic [NEXC-1:0] c);
    exc_valid = 1; exc_tag = t; exc_cause = c;
    tick();
    exc_valid = 0; exc_cause = '0;
  endtask

  task automatic complete(logic [31:0] pc);
    cmp_valid = 1; cmp_done = 1; cmp_pc = pc; cmp_next_pc = pc + 4;
    tick();
    cmp_valid = 0; cmp_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clr_in();
    rst_n = 0;
    hd = '0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1
    checks++;
    if (irq_take !== 1'b0) begin errors++; $display("FAIL R1: take=%0b expected 0", irq_take); end
    chk_sup("R1 reset", 1'b0);

    // R3 R4 R6: every cause mask, delivered lowest bit first
    for (int m = 1; m < 8; m++) begin
      logic [31:0] pc;
      pc = 32'h100 * m;
      report(hd, 3'(m));
      for (int i = 0; i < 3; i++) begin
        if (m[i]) begin
          complete(pc);
          chk_take("R4 R3 cause order", 1, 2 + i, pc);
          complete(pc);
          chk_take("R6 blocked while busy", 0, 0, 0);
          rfi_pulse();
        end
      end
      complete(pc);
      chk_take("R4 retire after causes", 0, 0, 0);
      hd = hd + 1;
    end

    // R2: younger reported first, older delivered first
    report(hd + 1, 3'b001);
    report(hd, 3'b100);
    complete(32'h2000);
    chk_take("R2 older first", 1, 4, 32'h2000);
    rfi_pulse();
    complete(32'h2000);
    chk_take("R2 older retires", 0, 0, 0);
    complete(32'h2004);
    chk_take("R2 younger next", 1, 2, 32'h2004);
    rfi_pulse();
    complete(32'h2004);
    chk_take("R2 younger retires", 0, 0, 0);
    hd = hd + 2;

    // R2: report to head in its completing cycle
    exc_valid = 1; exc_tag = hd; exc_cause = 3'b010;
    complete(32'h2100);
    exc_valid = 0; exc_cause = '0;
    chk_take("R2 same-cycle report", 1, 3, 32'h2100);
    rfi_pulse();
    complete(32'h2100);
    chk_take("R2 same-cycle retire", 0, 0, 0);
    hd = hd + 1;

    // R5: async masks x store queue x stage condition
    for (int a = 1; a < 4; a++) begin
      for (int sq = 0; sq < 2; sq++) begin
        for (int md = 0; md < 3; md++) begin
          logic et;
          int ety;
          logic [31:0] er;
          async_req = 2'(a); sq_empty = sq[0];
          cmp_valid = (md != 0); cmp_done = (md == 1);
          cmp_pc = 32'h3000; cmp_next_pc = 32'h3004;
          tick();
          clr_in();
          et  = sq[0] && (md != 2);
          ety = a[0] ? 5 : 6;
          er  = (md == 1) ? 32'h3004 : 32'h3000;
          chk_take("R5 async gating", et, ety, er);
          if (md == 1) hd = hd + 1;
          if (et) rfi_pulse();
        end
      end
    end

    // R8 R5: head cause beats async, async then taken with retirement
    report(hd, 3'b001);
    async_req = 2'b01;
    complete(32'h3100);
    chk_take("R8 cause over async", 1, 2, 32'h3100);
    rfi_pulse();
    complete(32'h3100);
    chk_take("R5 async on clean completion", 1, 5, 32'h3104);
    async_req = '0;
    hd = hd + 1;
    rfi_pulse();

    // R8 R7: every combination of reset, machine check, cause, async
    for (int c = 0; c < 16; c++) begin
      int ety;
      logic [31:0] er;
      if (c[1]) report(hd, 3'b010);
      rst_req = c[3]; mck_req = c[2]; async_req = {1'b0, c[0]}; sq_empty = 1;
      cmp_valid = 1; cmp_done = 1; cmp_pc = 32'h4000; cmp_next_pc = 32'h4004;
      tick();
      clr_in();
      er = 32'h4000;
      if (c[3]) ety = 0;
      else if (c[2]) ety = 1;
      else if (c[1]) ety = 3;
      else if (c[0]) begin ety = 5; er = 32'h4004; end
      else ety = -1;
      chk_take("R8 priority", ety >= 0, ety, er);
      rst_req = 1; tick(); rst_req = 0;
      chk_take("R7 reset while busy", 1, 0, 32'h0);
      hd = '0;
      rfi_pulse();
    end

    // R7: reset flushes pending causes
    report(hd, 3'b001);
    rst_req = 1; cmp_pc = 32'h5000; tick(); clr_in();
    chk_take("R7 reset take", 1, 0, 32'h5000);
    rfi_pulse();
    complete(32'h5000);
    chk_take("R7 flushed cause gone", 0, 0, 0);
    hd = 1;

    // R7: machine check preempts a running handler
    report(hd, 3'b001);
    complete(32'h6000);
    chk_take("R3 cause taken", 1, 2, 32'h6000);
    mck_req = 1; cmp_pc = 32'h6100; tick(); clr_in();
    chk_take("R7 machine check preempts", 1, 1, 32'h6100);
    rfi_pulse();
    complete(32'h6000);
    chk_take("R4 retire after preempt", 0, 0, 0);
    tick();
    chk_take("R9 strobe one cycle", 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule